// File: doc/BRIEF.md
# Straddled Completion Stream Splitter

This block takes a wide completion receive stream in which one beat may hold the tail of one packet and the head of the next. It produces a stream in which every beat belongs to one packet only. Each output beat is marked with packet start, packet end and the index of its last valid Dword. Each incoming beat carries a start flag for a packet that begins at Dword 0 and a start flag for a second packet that begins in the same beat. It also carries two end fields. In each end field, bit 0 says that a packet ends in the beat, and the bits above it give the Dword index of that packet's last Dword. A corruption flag on a packet's final beat means the whole packet must be thrown away. Every data byte also carries an odd-parity bit.

The block stores each packet in an internal buffer until the packet's end beat arrives. It then drains the stored beats to the output. A packet flagged as corrupted is therefore dropped without any partial output. Dwords keep their lane positions. Lanes that fall outside a packet's segment are zeroed, and their byte enables are cleared. A controller with four states runs the block:
- ST_GAP: no packet is open.
- ST_OPEN: a packet is being collected.
- ST_DRAIN: a stored packet is being emitted.
- ST_LOAD2: the held second segment is being moved into the buffer.

The transitions are:
- ST_GAP to ST_OPEN on a start beat.
- ST_GAP or ST_OPEN to ST_DRAIN on a clean end beat.
- ST_GAP or ST_OPEN to ST_GAP on a discarded packet or an overflow.
- ST_DRAIN to ST_LOAD2 after the last beat when a second segment is held.
- ST_DRAIN to ST_GAP after the last beat otherwise.
- ST_LOAD2 to ST_DRAIN if the held segment also ended.
- ST_LOAD2 to ST_OPEN if it did not.

Top module: `csplit_top`

## Requirements
- R1: After reset, in_ready is 1, and out_valid, err_parity and err_proto are 0.
- R2: Lanes and markers of a packet's beats:
  - The beats of a packet leave in order. out_sop is set only on the first beat and out_eop only on the last.
  - Dword d occupies data bits [32d+31:32d] and enable bits [4d+3:4d]. Dwords inside the segment are copied, and all other Dwords have data 0 and enables 0.
  - out_last_dw equals the end offset on the end beat and DW-1 on every other beat.
  - A first-segment packet covers Dwords 0 through its end offset on its end beat, and all Dwords on its other beats.
- R3: Nothing of a packet appears on the output before its end beat has been accepted. in_ready is 0 in every cycle in which out_valid is 1.
- R4: Two segments in one beat:
  - When a beat ends the first packet at offset k and also starts a second packet, the first packet is emitted completely before the second.
  - The second packet's first beat holds Dwords k+1 up to its own end offset, or up to DW-1 if it does not end in that beat.
  - in_ready stays low for one extra cycle, between the two drains.
  - With out_ready held high, in_ready is low for exactly 3 cycles after such a beat when both packets end in it.
- R5: A packet whose end beat carries the discard flag produces no output beat at all.
- R6: Parity checking:
  - If any byte i with its enable set has data byte i XOR parity bit i of even weight, err_parity pulses for one cycle in the cycle after that beat is accepted, and the data is still forwarded.
  - Bytes with enable 0 are not checked.
- R7: A second end field whose offset is not DW-2 or DW-1 raises err_proto and drops the second segment. The first packet is still emitted.
- R8: A beat accepted in ST_GAP without the first start flag raises err_proto and is dropped.
- R9: Buffer limit:
  - A packet of exactly MAX_BEATS beats is forwarded in full.
  - Beat MAX_BEATS+1 of a packet raises err_proto and drops the whole packet.
- R10: While out_valid is 1 and out_ready is 0, every output stays unchanged in the next cycle.
- R11: A first start flag while a packet is open raises err_proto, drops the open packet and starts a new one from that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DW*32 | Input beat data |
| in_be | input | DW*4 | Input byte enables |
| in_start_a | input | 1 | A packet starts at Dword 0 of this beat |
| in_end_a | input | $clog2(DW)+1 | First end: bit 0 flag, upper bits last Dword index |
| in_start_b | input | 1 | A second packet starts after the first ends |
| in_end_b | input | $clog2(DW)+1 | Second end: bit 0 flag, upper bits last Dword index |
| in_discard | input | 1 | Packet ending in this beat is corrupted |
| in_parity | input | DW*4 | Odd parity bit per data byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | DW*32 | Output beat data, lanes outside the segment zero |
| out_be | output | DW*4 | Output byte enables |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_last_dw | output | $clog2(DW) | Index of the last valid Dword of this beat |
| err_parity | output | 1 | One-cycle parity error pulse |
| err_proto | output | 1 | One-cycle protocol error pulse |

## Verification
On every cycle, the assertions check that:
- output beats hold steady under backpressure;
- input is stalled whenever output is valid;
- start markers follow end markers, and a non-final beat reports a full last Dword;
- a drained packet is always followed by an idle output cycle;
- error pulses only follow an accepted beat.

Only the bench scenarios can show which lanes survive a split, the order of the two packets, the exact stall length of a straddled beat, the dropping of discarded, overflowing and restarted packets, and which parity faults are ignored.

// File: rtl/csplit_pkg.sv
package csplit_pkg;

    typedef enum logic [1:0] {
        ST_GAP,
        ST_OPEN,
        ST_DRAIN,
        ST_LOAD2
    } split_state_e;

    // a byte and its parity bit together must carry an odd number of ones
    function automatic logic byte_par_ok(input logic [7:0] b, input logic p);
        return ^{b, p};
    endfunction

endpackage

// File: rtl/csplit_parity.sv
module csplit_parity #(
    parameter int BYTES = 32
) (
    input  logic [BYTES*8-1:0] data,
    input  logic [BYTES-1:0]   par,
    input  logic [BYTES-1:0]   be,
    output logic               bad
);
    logic [BYTES-1:0] miss;

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        assign miss[i] = be[i] & ~csplit_pkg::byte_par_ok(data[8*i +: 8], par[i]);
    end

    assign bad = |miss;
endmodule

// File: rtl/csplit_slicer.sv
module csplit_slicer #(
    parameter int DW = 8,
    localparam int OFF_W = $clog2(DW)
) (
    input  logic [DW*32-1:0] data,
    input  logic [DW*4-1:0]  be,
    input  logic             end_a,
    input  logic [OFF_W-1:0] off_a,
    input  logic             end_b,
    input  logic [OFF_W-1:0] off_b,
    output logic [DW*32-1:0] data_a,
    output logic [DW*4-1:0]  be_a,
    output logic [DW*32-1:0] data_b,
    output logic [DW*4-1:0]  be_b
);
    for (genvar d = 0; d < DW; d++) begin : g_dw
        localparam logic [OFF_W-1:0] DI = OFF_W'(d);
        logic in_a;
        logic in_b;
        // first segment: lanes up to the first end, or the whole beat
        assign in_a = !end_a || (DI <= off_a);
        // second segment: lanes after the first end, up to the second end
        assign in_b = end_a && (DI > off_a) && (!end_b || (DI <= off_b));
        assign data_a[32*d +: 32] = in_a ? data[32*d +: 32] : 32'd0;
        assign be_a[4*d +: 4]     = in_a ? be[4*d +: 4]     : 4'd0;
        assign data_b[32*d +: 32] = in_b ? data[32*d +: 32] : 32'd0;
        assign be_b[4*d +: 4]     = in_b ? be[4*d +: 4]     : 4'd0;
    end
endmodule

// File: rtl/csplit_store.sv
module csplit_store #(
    parameter int DATA_W = 256,
    parameter int BE_W   = 32,
    parameter int DEPTH  = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   wbe,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [BE_W-1:0]   rbe
);
    logic [DATA_W+BE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= {wbe, wdata};
        end
    end

    assign {rbe, rdata} = mem[raddr];
endmodule

// File: rtl/csplit_top.sv
module csplit_top #(
    parameter int DW        = 8,
    parameter int MAX_BEATS = 8,
    localparam int OFF_W = $clog2(DW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DW*32-1:0]   in_data,
    input  logic [DW*4-1:0]    in_be,
    input  logic               in_start_a,
    input  logic [OFF_W:0]     in_end_a,
    input  logic               in_start_b,
    input  logic [OFF_W:0]     in_end_b,
    input  logic               in_discard,
    input  logic [DW*4-1:0]    in_parity,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DW*32-1:0]   out_data,
    output logic [DW*4-1:0]    out_be,
    output logic               out_sop,
    output logic               out_eop,
    output logic [OFF_W-1:0]   out_last_dw,
    output logic               err_parity,
    output logic               err_proto
);
    import csplit_pkg::*;

    localparam int DATA_W = DW * 32;
    localparam int BE_W   = DW * 4;
    localparam int AW     = $clog2(MAX_BEATS);
    localparam int CNT_W  = $clog2(MAX_BEATS + 1);

    split_state_e state_q, state_d;

    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [AW-1:0]     rd_q, rd_d;
    logic [OFF_W-1:0]  eoff_q, eoff_d;
    logic              pv_q, pv_d;
    logic [DATA_W-1:0] pdata_q;
    logic [BE_W-1:0]   pbe_q;
    logic              pend_end_q;
    logic [OFF_W-1:0]  poff_q;
    logic              err_par_q, err_pro_q;

    logic              accept;
    logic              end_a, end_b, b_off_ok, par_bad, is_last;
    logic [OFF_W-1:0]  off_a, off_b;
    logic [DATA_W-1:0] seg_a_data, seg_b_data, rd_data;
    logic [BE_W-1:0]   seg_a_be, seg_b_be, rd_be;
    logic              we, load_pend, proto;
    logic [AW-1:0]     waddr;
    logic [DATA_W-1:0] wdata;
    logic [BE_W-1:0]   wbe;

    assign in_ready = (state_q == ST_GAP) || (state_q == ST_OPEN);
    assign accept   = in_valid && in_ready;
    assign end_a    = in_end_a[0];
    assign off_a    = in_end_a[OFF_W:1];
    assign end_b    = in_end_b[0];
    assign off_b    = in_end_b[OFF_W:1];
    assign b_off_ok = off_b >= OFF_W'(DW - 2);
    assign is_last  = rd_q == AW'(cnt_q - CNT_W'(1));

    csplit_parity #(.BYTES(BE_W)) par_i (
        .data (in_data),
        .par  (in_parity),
        .be   (in_be),
        .bad  (par_bad)
    );

    csplit_slicer #(.DW(DW)) slc_i (
        .data   (in_data),
        .be     (in_be),
        .end_a  (end_a),
        .off_a  (off_a),
        .end_b  (end_b),
        .off_b  (off_b),
        .data_a (seg_a_data),
        .be_a   (seg_a_be),
        .data_b (seg_b_data),
        .be_b   (seg_b_be)
    );

    csplit_store #(.DATA_W(DATA_W), .BE_W(BE_W), .DEPTH(MAX_BEATS)) st_i (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .wbe   (wbe),
        .raddr (rd_q),
        .rdata (rd_data),
        .rbe   (rd_be)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GAP;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and buffer control
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        rd_d      = rd_q;
        eoff_d    = eoff_q;
        pv_d      = pv_q;
        we        = 1'b0;
        waddr     = cnt_q[AW-1:0];
        wdata     = seg_a_data;
        wbe       = seg_a_be;
        load_pend = 1'b0;
        proto     = 1'b0;
        unique case (state_q)
            ST_GAP, ST_OPEN: begin
                if (accept) begin
                    if (state_q == ST_GAP && !in_start_a) begin
                        proto = 1'b1;
                    end else if (!in_start_a && cnt_q == CNT_W'(MAX_BEATS)) begin
                        proto   = 1'b1;
                        cnt_d   = '0;
                        state_d = ST_GAP;
                    end else begin
                        if (state_q == ST_OPEN && in_start_a) begin
                            proto = 1'b1;
                        end
                        if (in_discard && !end_a) begin
                            proto = 1'b1;
                        end
                        if (end_b && !in_start_b) begin
                            proto = 1'b1;
                        end
                        we    = 1'b1;
                        waddr = in_start_a ? '0 : cnt_q[AW-1:0];
                        cnt_d = in_start_a ? CNT_W'(1) : cnt_q + CNT_W'(1);
                        if (end_a) begin
                            if (in_discard) begin
                                cnt_d   = '0;
                                state_d = ST_GAP;
                            end else begin
                                eoff_d  = off_a;
                                rd_d    = '0;
                                state_d = ST_DRAIN;
                            end
                            if (in_start_b) begin
                                if (in_discard || (end_b && !b_off_ok)) begin
                                    proto = 1'b1;
                                end else begin
                                    load_pend = 1'b1;
                                    pv_d      = 1'b1;
                                end
                            end
                        end else begin
                            state_d = ST_OPEN;
                            if (in_start_b) begin
                                proto = 1'b1;
                            end
                        end
                    end
                end
            end
            ST_DRAIN: begin
                if (out_ready) begin
                    if (is_last) begin
                        rd_d    = '0;
                        cnt_d   = '0;
                        state_d = pv_q ? ST_LOAD2 : ST_GAP;
                    end else begin
                        rd_d = rd_q + AW'(1);
                    end
                end
            end
            ST_LOAD2: begin
                we    = 1'b1;
                waddr = '0;
                wdata = pdata_q;
                wbe   = pbe_q;
                cnt_d = CNT_W'(1);
                rd_d  = '0;
                pv_d  = 1'b0;
                if (pend_end_q) begin
                    eoff_d  = poff_q;
                    state_d = ST_DRAIN;
                end else begin
                    state_d = ST_OPEN;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        out_valid   = state_q == ST_DRAIN;
        out_sop     = out_valid && (rd_q == '0);
        out_eop     = out_valid && is_last;
        out_last_dw = out_eop ? eoff_q : OFF_W'(DW - 1);
        out_data    = out_valid ? rd_data : '0;
        out_be      = out_valid ? rd_be : '0;
        err_parity  = err_par_q;
        err_proto   = err_pro_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            rd_q      <= '0;
            eoff_q    <= '0;
            pv_q      <= 1'b0;
            err_par_q <= 1'b0;
            err_pro_q <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            rd_q      <= rd_d;
            eoff_q    <= eoff_d;
            pv_q      <= pv_d;
            err_par_q <= accept && par_bad;
            err_pro_q <= proto;
        end
    end

    always_ff @(posedge clk) begin
        if (load_pend) begin
            pdata_q    <= seg_b_data;
            pbe_q      <= seg_b_be;
            pend_end_q <= end_b;
            poff_q     <= off_b;
        end
    end
endmodule

// File: rtl/csplit_checker.sv
module csplit_checker #(
    parameter int DW = 8,
    localparam int OFF_W = $clog2(DW)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [DW*32-1:0] out_data,
    input logic [DW*4-1:0]  out_be,
    input logic             out_sop,
    input logic             out_eop,
    input logic [OFF_W-1:0] out_last_dw,
    input logic             err_parity,
    input logic             err_proto
);
    logic in_pkt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_pkt <= 1'b0;
        end else if (out_valid && out_ready) begin
            in_pkt <= !out_eop;
        end
    end

    p_stall_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_split_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> !out_valid);

    p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be)
            && $stable(out_sop) && $stable(out_eop) && $stable(out_last_dw)));

    p_sop_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_pkt) |-> out_sop);

    p_sop_inner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_pkt) |-> !out_sop);

    p_full_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eop) |-> (out_last_dw == OFF_W'(DW - 1)));

    p_par_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity |-> $past(in_valid && in_ready));

    p_proto_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_proto |-> $past(in_valid && in_ready));
endmodule

bind csplit_top csplit_checker #(.DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_be      (out_be),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .out_last_dw (out_last_dw),
    .err_parity  (err_parity),
    .err_proto   (err_proto)
);

// File: tb/csplit_top_tb_top.sv
module csplit_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] in_data = '0;
    logic [31:0]  in_be = '0;
    logic         in_start_a = 1'b0;
    logic [3:0]   in_end_a = '0;
    logic         in_start_b = 1'b0;
    logic [3:0]   in_end_b = '0;
    logic         in_discard = 1'b0;
    logic [31:0]  in_parity = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [255:0] out_data;
    logic [31:0]  out_be;
    logic         out_sop, out_eop;
    logic [2:0]   out_last_dw;
    logic         err_parity, err_proto;

    int total = 0;
    int bad = 0;
    int cap_n = 0;
    int par_n = 0;
    int pro_n = 0;
    int overlap_n = 0;
    int cyc = 0;
    bit bp_en = 1'b0;
    bit done = 1'b0;

    logic [255:0] cap_data [64];
    logic [31:0]  cap_be   [64];
    logic         cap_sop  [64];
    logic         cap_eop  [64];
    logic [2:0]   cap_ldw  [64];

    csplit_top dut_i (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_data (in_data), .in_be (in_be),
        .in_start_a (in_start_a), .in_end_a (in_end_a),
        .in_start_b (in_start_b), .in_end_b (in_end_b),
        .in_discard (in_discard), .in_parity (in_parity),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_data (out_data), .out_be (out_be),
        .out_sop (out_sop), .out_eop (out_eop),
        .out_last_dw (out_last_dw),
        .err_parity (err_parity), .err_proto (err_proto)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        cyc <= cyc + 1;
        out_ready <= bp_en ? (cyc % 3 != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                cap_data[cap_n % 64] <= out_data;
                cap_be[cap_n % 64]   <= out_be;
                cap_sop[cap_n % 64]  <= out_sop;
                cap_eop[cap_n % 64]  <= out_eop;
                cap_ldw[cap_n % 64]  <= out_last_dw;
                cap_n <= cap_n + 1;
            end
            if (err_parity) par_n <= par_n + 1;
            if (err_proto) pro_n <= pro_n + 1;
            if (out_valid && in_ready) overlap_n <= overlap_n + 1;
        end
    end

    function automatic logic [255:0] pat(input int s);
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[32*k +: 32] = 32'h5A00_0000 + (s << 12) + (k * 37);
        return r;
    endfunction

    function automatic logic [255:0] dmask(input int lo, input int hi);
        logic [255:0] m = '0;
        for (int k = lo; k <= hi; k++) m[32*k +: 32] = '1;
        return m;
    endfunction

    function automatic logic [31:0] bmask(input int lo, input int hi);
        logic [31:0] m = '0;
        for (int k = lo; k <= hi; k++) m[4*k +: 4] = '1;
        return m;
    endfunction

    function automatic logic [31:0] good_par(input logic [255:0] d);
        logic [31:0] p;
        for (int i = 0; i < 32; i++) p[i] = ~^d[8*i +: 8];
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put_beat(input logic [255:0] d, input logic [31:0] be, input bit sa,
                            input logic [3:0] ea, input bit sb, input logic [3:0] eb,
                            input bit disc, input int bad_byte);
        logic [31:0] p;
        p = good_par(d);
        if (bad_byte >= 0) p[bad_byte] = ~p[bad_byte];
        in_data = d; in_be = be; in_start_a = sa; in_end_a = ea;
        in_start_b = sb; in_end_b = eb; in_discard = disc; in_parity = p;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_start_a = 0; in_end_a = 0; in_start_b = 0; in_end_b = 0; in_discard = 0;
    endtask

    task automatic settle();
        repeat (40) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        chk(err_parity == 1'b0 && err_proto == 1'b0, "R1", "errors", {err_parity, err_proto}, 0);
    endtask

    task automatic t_single();
        int b = cap_n;
        put_beat(pat(1), '1, 1, {3'd5, 1'b1}, 0, 0, 0, -1);
        settle();
        chk(cap_n - b == 1, "R2", "beat count", cap_n - b, 1);
        chk(cap_data[b] == (pat(1) & dmask(0, 5)), "R2", "data", cap_data[b], pat(1) & dmask(0, 5));
        chk(cap_be[b] == bmask(0, 5), "R2", "be", cap_be[b], bmask(0, 5));
        chk(cap_sop[b] && cap_eop[b], "R2", "sop/eop", {cap_sop[b], cap_eop[b]}, 2'b11);
        chk(cap_ldw[b] == 3'd5, "R2", "last dw", cap_ldw[b], 5);
    endtask

    task automatic t_multi();
        int b = cap_n;
        put_beat(pat(2), '1, 1, 0, 0, 0, 0, -1);
        put_beat(pat(3), '1, 0, 0, 0, 0, 0, -1);
        repeat (6) @(posedge clk);
        chk(cap_n == b, "R3", "no early output", cap_n - b, 0);
        put_beat(pat(4), '1, 0, {3'd4, 1'b1}, 0, 0, 0, -1);
        settle();
        chk(cap_n - b == 3, "R2", "beat count", cap_n - b, 3);
        chk(cap_sop[b] && !cap_sop[b+1] && !cap_sop[b+2], "R2", "sop",
            {cap_sop[b], cap_sop[b+1], cap_sop[b+2]}, 3'b100);
        chk(!cap_eop[b] && !cap_eop[b+1] && cap_eop[b+2], "R2", "eop",
            {cap_eop[b], cap_eop[b+1], cap_eop[b+2]}, 3'b001);
        chk(cap_ldw[b] == 3'd7 && cap_ldw[b+2] == 3'd4, "R2", "last dw",
            {cap_ldw[b], cap_ldw[b+2]}, {3'd7, 3'd4});
        chk(cap_data[b+1] == pat(3), "R2", "middle data", cap_data[b+1], pat(3));
        chk(cap_data[b+2] == (pat(4) & dmask(0, 4)), "R2", "end data", cap_data[b+2], pat(4) & dmask(0, 4));
        chk(overlap_n == 0, "R3", "ready while out valid", overlap_n, 0);
    endtask

    task automatic t_straddle();
        int b = cap_n;
        int n = 0;
        put_beat(pat(5), '1, 1, {3'd2, 1'b1}, 1, {3'd7, 1'b1}, 0, -1);
        while (!in_ready && n < 50) begin
            @(posedge clk);
            #1;
            n++;
        end
        chk(n == 3, "R4", "stall cycles", n, 3);
        settle();
        chk(cap_n - b == 2, "R4", "beat count", cap_n - b, 2);
        chk(cap_data[b] == (pat(5) & dmask(0, 2)) && cap_ldw[b] == 3'd2, "R4", "first packet",
            cap_data[b], pat(5) & dmask(0, 2));
        chk(cap_data[b+1] == (pat(5) & dmask(3, 7)) && cap_be[b+1] == bmask(3, 7), "R4",
            "second packet", cap_data[b+1], pat(5) & dmask(3, 7));
        chk(cap_sop[b+1] && cap_eop[b+1] && cap_ldw[b+1] == 3'd7, "R4", "second markers",
            {cap_sop[b+1], cap_eop[b+1], cap_ldw[b+1]}, {2'b11, 3'd7});
        b = cap_n;
        put_beat(pat(6), '1, 1, {3'd3, 1'b1}, 1, 0, 0, -1);
        put_beat(pat(7), '1, 0, {3'd6, 1'b1}, 0, 0, 0, -1);
        settle();
        chk(cap_n - b == 3, "R4", "open second count", cap_n - b, 3);
        chk(cap_data[b+1] == (pat(6) & dmask(4, 7)) && cap_sop[b+1] && !cap_eop[b+1]
            && cap_ldw[b+1] == 3'd7, "R4", "open second head", cap_data[b+1], pat(6) & dmask(4, 7));
        chk(cap_data[b+2] == (pat(7) & dmask(0, 6)) && cap_eop[b+2] && cap_ldw[b+2] == 3'd6,
            "R4", "open second tail", cap_data[b+2], pat(7) & dmask(0, 6));
    endtask

    task automatic t_discard();
        int b = cap_n;
        int e = pro_n;
        put_beat(pat(8), '1, 1, 0, 0, 0, 0, -1);
        put_beat(pat(9), '1, 0, {3'd5, 1'b1}, 0, 0, 1, -1);
        settle();
        chk(cap_n == b, "R5", "discarded output", cap_n - b, 0);
        chk(pro_n == e, "R5", "no proto error", pro_n - e, 0);
        put_beat(pat(10), '1, 1, {3'd7, 1'b1}, 0, 0, 0, -1);
        settle();
        chk(cap_n - b == 1 && cap_data[b] == pat(10), "R5", "next packet", cap_data[b], pat(10));
    endtask

    task automatic t_parity();
        int b = cap_n;
        int e = par_n;
        put_beat(pat(11), '1, 1, {3'd7, 1'b1}, 0, 0, 0, 9);
        settle();
        chk(par_n - e == 1, "R6", "parity pulse", par_n - e, 1);
        chk(cap_n - b == 1 && cap_data[b] == pat(11), "R6", "data forwarded", cap_data[b], pat(11));
        e = par_n;
        put_beat(pat(12), 32'h0000_FFFF, 1, {3'd7, 1'b1}, 0, 0, 0, 20);
        settle();
        chk(par_n == e, "R6", "disabled byte ignored", par_n - e, 0);
        chk(cap_be[b+1] == 32'h0000_FFFF, "R6", "be forwarded", cap_be[b+1], 32'h0000_FFFF);
    endtask

    task automatic t_bad_off();
        int b = cap_n;
        int e = pro_n;
        put_beat(pat(13), '1, 1, {3'd2, 1'b1}, 1, {3'd4, 1'b1}, 0, -1);
        settle();
        chk(pro_n - e == 1, "R7", "proto pulse", pro_n - e, 1);
        chk(cap_n - b == 1 && cap_data[b] == (pat(13) & dmask(0, 2)), "R7", "first kept",
            cap_data[b], pat(13) & dmask(0, 2));
    endtask

    task automatic t_no_start();
        int b = cap_n;
        int e = pro_n;
        put_beat(pat(14), '1, 0, {3'd3, 1'b1}, 0, 0, 0, -1);
        settle();
        chk(pro_n - e == 1, "R8", "proto pulse", pro_n - e, 1);
        chk(cap_n == b, "R8", "dropped", cap_n - b, 0);
    endtask

    task automatic t_overflow();
        int b = cap_n;
        int e = pro_n;
        put_beat(pat(15), '1, 1, 0, 0, 0, 0, -1);
        for (int i = 0; i < 6; i++) put_beat(pat(16 + i), '1, 0, 0, 0, 0, 0, -1);
        put_beat(pat(40), '1, 0, {3'd7, 1'b1}, 0, 0, 0, -1);
        settle();
        chk(cap_n - b == 8, "R9", "full packet", cap_n - b, 8);
        chk(cap_data[b+7] == pat(40) && cap_eop[b+7], "R9", "full last", cap_data[b+7], pat(40));
        b = cap_n;
        put_beat(pat(41), '1, 1, 0, 0, 0, 0, -1);
        for (int i = 0; i < 8; i++) put_beat(pat(42 + i), '1, 0, 0, 0, 0, 0, -1);
        put_beat(pat(50), '1, 0, {3'd1, 1'b1}, 0, 0, 0, -1);
        settle();
        chk(pro_n - e == 2, "R9", "overflow errors", pro_n - e, 2);
        chk(cap_n == b, "R9", "overflow dropped", cap_n - b, 0);
    endtask

    task automatic t_backpressure();
        int b = cap_n;
        bp_en = 1'b1;
        put_beat(pat(20), '1, 1, 0, 0, 0, 0, -1);
        put_beat(pat(21), '1, 0, 0, 0, 0, 0, -1);
        put_beat(pat(22), '1, 0, {3'd7, 1'b1}, 0, 0, 0, -1);
        settle();
        bp_en = 1'b0;
        chk(cap_n - b == 3, "R10", "count", cap_n - b, 3);
        for (int i = 0; i < 3; i++)
            chk(cap_data[b+i] == pat(20 + i), "R10", "order", cap_data[b+i], pat(20 + i));
    endtask

    task automatic t_restart();
        int b = cap_n;
        int e = pro_n;
        put_beat(pat(30), '1, 1, 0, 0, 0, 0, -1);
        put_beat(pat(31), '1, 1, {3'd7, 1'b1}, 0, 0, 0, -1);
        settle();
        chk(pro_n - e == 1, "R11", "proto pulse", pro_n - e, 1);
        chk(cap_n - b == 1 && cap_data[b] == pat(31) && cap_sop[b], "R11", "new packet only",
            cap_data[b], pat(31));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_single();
        t_multi();
        t_straddle();
        t_discard();
        t_parity();
        t_bad_off();
        t_no_start();
        t_overflow();
        t_backpressure();
        t_restart();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule